// File: doc/BRIEF.md
# Dual-Rate LED Dimming Controller

This block drives sixteen open-drain LED pads. A 2-bit selector field for each pad picks one of four behaviours: released (high impedance, LED dark), pulled low (LED lit at full current), or blinking under one of two shared PWM channels. Each channel has an 8-bit prescaler and an 8-bit duty value. The prescaler sets the blink period and the duty value sets the lit fraction of each period. A free-running timebase enable (nominally 256 × 160 Hz) clocks both channels, so the blink period is (prescaler + 1) / 160 s and the lit fraction is duty / 256.

A host bus interface writes the configuration through a simple strobe, address and data port. The same interface reads back the configuration and two status bytes, which show the synchronised level of every pad. A pad left released can therefore serve as a general-purpose input. New prescaler and duty values are held until the affected channel completes its current period, which keeps partial pulses off the pads. Selector changes apply at once.

Top module: `dual_rate_led_dimmer`

## Requirements
- R1: While `rst_n` is low, and right after it rises, every `led_oe_o` bit is 0. Reads return 0x00 at addresses 2 and 4 (prescalers), 0x80 at addresses 3 and 5 (duty values), and 0x00 at addresses 6 to 9 (selectors).
- R2: Address 2 holds the channel 0 prescaler and address 3 its duty value. Addresses 4 and 5 hold the same pair for channel 1. Addresses 6, 7, 8 and 9 are the selector bytes for LED0–3, LED4–7, LED8–11 and LED12–15. A read returns the last value written, starting on the cycle after the write.
- R3: In selector byte b, LED 4b+k is controlled by bits [2k+1:2k]. Code 00 gives `led_oe_o`=0 and code 01 gives `led_oe_o`=1. Code 10 follows channel 0 and code 11 follows channel 1. `led_lvl_o` is always 0.
- R4: Address 0 reads pads 7..0 and address 1 reads pads 15..8, with bit i being pad i (or pad i+8). A pad change shows up after exactly two rising clock edges.
- R5: With prescaler 0 and a tick on every cycle, a pad on a channel is lit for exactly `duty` cycles in every 256 consecutive cycles.
- R6: A duty value of 0 keeps the channel's pads dark for the whole period.
- R7: Each phase step lasts prescaler+1 ticks. With prescaler 3, successive rising edges on a channel's pad are 1024 ticks apart, and the pad is lit 4×duty ticks in every 1024.
- R8: While `tick_i` is low, the pads do not change.
- R9: A new prescaler or duty value takes effect only when the channel's phase wraps from 255 to 0. Until then the old value keeps driving the pads, although the new value already reads back.
- R10: Writes to addresses 0, 1 and 10–15 change nothing. Reads from addresses 10–15 return 0.
- R11: Asserting `rst_n` during operation restores all R1 defaults.
- R12: Write strobes presented while `rst_n` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase enable, one pulse per prescaler step |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 8 | Read data, combinational from `rd_addr_i` |
| led_pin_i | input | 16 | Sampled pad levels |
| led_oe_o | output | 16 | Pad pull-down enable, 1 = LED lit |
| led_lvl_o | output | 16 | Pad output level, tied low (open drain) |

## Verification
A corrupt phase or prescale counter in a channel shifts the edges on every pad mapped to that channel. A reference model compared every cycle catches this on the first step that lands at the wrong time, which is at most prescaler+1 ticks later. A wrong held duty or prescaler value can stay hidden until the next phase wrap, up to 256 × (prescaler+1) ticks. The bench therefore counts lit cycles over whole periods and measures edge spacing. A selector or register-file fault shows up on `led_oe_o` or `rd_data_o` in the very cycle it occurs. A stuck synchroniser stage shows up two edges after a pad change.

// File: rtl/ldim_pkg.sv
package ldim_pkg;
    localparam int DATA_W       = 8;
    localparam int N_CH         = 2;
    localparam int LED_PER_SEL  = DATA_W / 2;
    localparam int LED_PER_STAT = DATA_W;

    typedef enum logic [1:0] {
        SEL_OFF = 2'b00,
        SEL_ON  = 2'b01,
        SEL_CH0 = 2'b10,
        SEL_CH1 = 2'b11
    } sel_e;

    localparam logic [DATA_W-1:0] PRE_RST  = 8'h00;
    localparam logic [DATA_W-1:0] DUTY_RST = 8'h80;
endpackage

// File: rtl/ldim_regs.sv
module ldim_regs
    import ldim_pkg::*;
#(
    parameter int NUM_LED = 16,
    parameter int ADDR_W  = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en_i,
    input  logic [ADDR_W-1:0]                   wr_addr_i,
    input  logic [DATA_W-1:0]                   wr_data_i,
    input  logic [ADDR_W-1:0]                   rd_addr_i,
    output logic [DATA_W-1:0]                   rd_data_o,
    input  logic [NUM_LED-1:0]                  status_i,
    output logic [N_CH-1:0][DATA_W-1:0]         pre_o,
    output logic [N_CH-1:0][DATA_W-1:0]         duty_o,
    output logic [2*NUM_LED-1:0]                sel_o
);
    localparam int N_STAT = NUM_LED / LED_PER_STAT;
    localparam int N_SEL  = NUM_LED / LED_PER_SEL;
    localparam int A_CH   = N_STAT;
    localparam int A_SEL  = N_STAT + 2 * N_CH;

    typedef struct packed {
        logic [N_SEL-1:0][DATA_W-1:0] sel;
        logic [N_CH-1:0][DATA_W-1:0]  duty;
        logic [N_CH-1:0][DATA_W-1:0]  pre;
    } cfg_t;

    localparam cfg_t CFG_RST = '{sel: '0, duty: {N_CH{DUTY_RST}}, pre: {N_CH{PRE_RST}}};

    cfg_t cfg_d, cfg_q;

    // Next-state: decode the write strobe onto the addressed byte.
    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            for (int c = 0; c < N_CH; c++) begin
                if (wr_addr_i == ADDR_W'(A_CH + 2 * c))
                    cfg_d.pre[c] = wr_data_i;
                if (wr_addr_i == ADDR_W'(A_CH + 2 * c + 1))
                    cfg_d.duty[c] = wr_data_i;
            end
            for (int s = 0; s < N_SEL; s++) begin
                if (wr_addr_i == ADDR_W'(A_SEL + s))
                    cfg_d.sel[s] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    // Readback mux; unmapped addresses read as zero.
    always_comb begin
        rd_data_o = '0;
        for (int st = 0; st < N_STAT; st++) begin
            if (rd_addr_i == ADDR_W'(st))
                rd_data_o = status_i[st*DATA_W +: DATA_W];
        end
        for (int c = 0; c < N_CH; c++) begin
            if (rd_addr_i == ADDR_W'(A_CH + 2 * c))
                rd_data_o = cfg_q.pre[c];
            if (rd_addr_i == ADDR_W'(A_CH + 2 * c + 1))
                rd_data_o = cfg_q.duty[c];
        end
        for (int s = 0; s < N_SEL; s++) begin
            if (rd_addr_i == ADDR_W'(A_SEL + s))
                rd_data_o = cfg_q.sel[s];
        end
    end

    assign pre_o  = cfg_q.pre;
    assign duty_o = cfg_q.duty;
    assign sel_o  = cfg_q.sel;
endmodule

// File: rtl/ldim_channel.sv
module ldim_channel
    import ldim_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] pre_cfg_i,
    input  logic [CNT_W-1:0] duty_cfg_i,
    output logic             on_o,
    output logic [CNT_W-1:0] phase_o,
    output logic [CNT_W-1:0] duty_act_o
);
    localparam logic [CNT_W-1:0] PHASE_LAST = '1;

    typedef struct packed {
        logic [CNT_W-1:0] pcnt;
        logic [CNT_W-1:0] phase;
        logic [CNT_W-1:0] pre_act;
        logic [CNT_W-1:0] duty_act;
    } ch_t;

    localparam ch_t CH_RST = '{pcnt: '0, phase: '0, pre_act: CNT_W'(PRE_RST), duty_act: CNT_W'(DUTY_RST)};

    ch_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (tick_i) begin
            if (ch_q.pcnt == ch_q.pre_act) begin
                ch_d.pcnt  = '0;
                ch_d.phase = ch_q.phase + 1'b1;
                // Held settings are taken only at the period boundary.
                if (ch_q.phase == PHASE_LAST) begin
                    ch_d.pre_act  = pre_cfg_i;
                    ch_d.duty_act = duty_cfg_i;
                end
            end else begin
                ch_d.pcnt = ch_q.pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= CH_RST;
        else        ch_q <= ch_d;
    end

    assign on_o       = (ch_q.phase < ch_q.duty_act);
    assign phase_o    = ch_q.phase;
    assign duty_act_o = ch_q.duty_act;
endmodule

// File: rtl/ldim_sync.sv
module ldim_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din_i;
        for (int s = 1; s < STAGES; s++)
            pipe_d[s] = pipe_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ldim_outmap.sv
module ldim_outmap
    import ldim_pkg::*;
#(
    parameter int NUM_LED = 16
) (
    input  logic [2*NUM_LED-1:0] sel_i,
    input  logic [N_CH-1:0]      ch_on_i,
    output logic [NUM_LED-1:0]   oe_o
);
    function automatic logic pad_drive(input logic [1:0] code, input logic [N_CH-1:0] on);
        logic r;
        case (code)
            SEL_OFF: r = 1'b0;
            SEL_ON:  r = 1'b1;
            SEL_CH0: r = on[0];
            default: r = on[1];
        endcase
        return r;
    endfunction

    for (genvar i = 0; i < NUM_LED; i++) begin : g_pad
        assign oe_o[i] = pad_drive(sel_i[2*i +: 2], ch_on_i);
    end
endmodule

// File: rtl/dual_rate_led_dimmer.sv
module dual_rate_led_dimmer
    import ldim_pkg::*;
#(
    parameter int NUM_LED     = 16,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    input  logic [NUM_LED-1:0] led_pin_i,
    output logic [NUM_LED-1:0] led_oe_o,
    output logic [NUM_LED-1:0] led_lvl_o
);
    logic [N_CH-1:0][DATA_W-1:0] cfg_pre;
    logic [N_CH-1:0][DATA_W-1:0] cfg_duty;
    logic [2*NUM_LED-1:0]        sel_flat;
    logic [NUM_LED-1:0]          stat_sync;
    logic [N_CH-1:0]             ch_on;
    logic [N_CH-1:0][DATA_W-1:0] ch_phase;
    logic [N_CH-1:0][DATA_W-1:0] ch_duty;

    ldim_regs #(.NUM_LED(NUM_LED), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .status_i  (stat_sync),
        .pre_o     (cfg_pre),
        .duty_o    (cfg_duty),
        .sel_o     (sel_flat)
    );

    ldim_sync #(.WIDTH(NUM_LED), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (led_pin_i),
        .dout_o (stat_sync)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        ldim_channel #(.CNT_W(DATA_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick_i),
            .pre_cfg_i  (cfg_pre[c]),
            .duty_cfg_i (cfg_duty[c]),
            .on_o       (ch_on[c]),
            .phase_o    (ch_phase[c]),
            .duty_act_o (ch_duty[c])
        );
    end

    ldim_outmap #(.NUM_LED(NUM_LED)) u_map (
        .sel_i   (sel_flat),
        .ch_on_i (ch_on),
        .oe_o    (led_oe_o)
    );

    // Open-drain pads: the level is always low, the enable decides.
    assign led_lvl_o = '0;
endmodule

// File: rtl/ldim_checker.sv
module ldim_checker
    import ldim_pkg::*;
#(
    parameter int NUM_LED = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        tick,
    input logic [2*NUM_LED-1:0]        sel,
    input logic [NUM_LED-1:0]          oe,
    input logic [N_CH-1:0]             ch_on,
    input logic [N_CH-1:0][DATA_W-1:0] phase,
    input logic [N_CH-1:0][DATA_W-1:0] duty,
    input logic [NUM_LED-1:0]          pins,
    input logic [NUM_LED-1:0]          status
);
    logic [NUM_LED-1:0] off_mask, on_mask;
    logic [1:0]         since_rst;

    always_comb begin
        for (int i = 0; i < NUM_LED; i++) begin
            off_mask[i] = (sel[2*i +: 2] == 2'b00);
            on_mask[i]  = (sel[2*i +: 2] == 2'b01);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    always @(posedge clk) begin
        if (!rst_n) p_reset_dark_r1: assert (oe == '0);
    end

    p_off_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (oe & off_mask) == '0);
    p_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (oe & on_mask) == on_mask);
    p_sync_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (status == $past(pins, 2)));
    p_zero_dark0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (duty[0] == '0) |-> !ch_on[0]);
    p_zero_dark1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (duty[1] == '0) |-> !ch_on[1]);
    p_freeze0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase[0]));
    p_freeze1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase[1]));
    p_wrap_load0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty[0]) |-> (phase[0] == '0));
    p_wrap_load1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty[1]) |-> (phase[1] == '0));
endmodule

bind dual_rate_led_dimmer ldim_checker #(.NUM_LED(NUM_LED)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_i),
    .sel    (sel_flat),
    .oe     (led_oe_o),
    .ch_on  (ch_on),
    .phase  (ch_phase),
    .duty   (ch_duty),
    .pins   (led_pin_i),
    .status (stat_sync)
);

// File: tb/dual_rate_led_dimmer_tb_top.sv
module dual_rate_led_dimmer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        tick_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [15:0] pins = '0;
    logic [15:0] led_oe;
    logic [15:0] led_lvl;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit cmp_on = 0;

    always #10 clk = ~clk;

    dual_rate_led_dimmer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_en),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .led_pin_i(pins), .led_oe_o(led_oe), .led_lvl_o(led_lvl)
    );

    // ---------------- behavioural reference ----------------
    int m_pre[2], m_duty[2], m_pact[2], m_dact[2], m_pcnt[2], m_ph[2];
    int m_sel[4];
    logic [15:0] m_pipe[$];

    task automatic m_reset();
        for (int c = 0; c < 2; c++) begin
            m_pre[c] = 0; m_duty[c] = 128; m_pact[c] = 0; m_dact[c] = 128;
            m_pcnt[c] = 0; m_ph[c] = 0;
        end
        for (int s = 0; s < 4; s++) m_sel[s] = 0;
        m_pipe = {16'h0, 16'h0};
    endtask

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            for (int c = 0; c < 2; c++) begin
                if (tick_en) begin
                    if (m_pcnt[c] >= m_pact[c]) begin
                        m_pcnt[c] = 0;
                        if (m_ph[c] == 255) begin
                            m_ph[c] = 0; m_pact[c] = m_pre[c]; m_dact[c] = m_duty[c];
                        end else m_ph[c] = m_ph[c] + 1;
                    end else m_pcnt[c] = m_pcnt[c] + 1;
                end
            end
            m_pipe.push_back(pins);
            void'(m_pipe.pop_front());
            if (wr_en) begin
                case (int'(wr_addr))
                    2: m_pre[0] = int'(wr_data);
                    3: m_duty[0] = int'(wr_data);
                    4: m_pre[1] = int'(wr_data);
                    5: m_duty[1] = int'(wr_data);
                    6, 7, 8, 9: m_sel[int'(wr_addr) - 6] = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    function automatic int m_field(int i);
        return (m_sel[i / 4] >> (2 * (i % 4))) & 3;
    endfunction

    function automatic logic [15:0] m_oe();
        logic [15:0] r;
        for (int i = 0; i < 16; i++) begin
            case (m_field(i))
                0: r[i] = 1'b0;
                1: r[i] = 1'b1;
                2: r[i] = (m_ph[0] < m_dact[0]);
                default: r[i] = (m_ph[1] < m_dact[1]);
            endcase
        end
        return r;
    endfunction

    function automatic logic [7:0] m_rd(int a);
        case (a)
            0: return m_pipe[0][7:0];
            1: return m_pipe[0][15:8];
            2: return 8'(m_pre[0]);
            3: return 8'(m_duty[0]);
            4: return 8'(m_pre[1]);
            5: return 8'(m_duty[1]);
            6, 7, 8, 9: return 8'(m_sel[a - 6]);
            default: return 8'h00;
        endcase
    endfunction

    function automatic string oe_tag(logic [15:0] diff);
        for (int i = 0; i < 16; i++) begin
            if (diff[i]) begin
                if (m_field(i) < 2) return "R3";
                if (m_pre[m_field(i) - 2] != m_pact[m_field(i) - 2] ||
                    m_duty[m_field(i) - 2] != m_dact[m_field(i) - 2]) return "R9";
                return "R5";
            end
        end
        return "R5";
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, sampled mid low phase.
    always @(negedge clk) begin
        #5;
        if (rst_n && cmp_on && !done) begin
            chk(led_oe === m_oe(), oe_tag(led_oe ^ m_oe()), int'(led_oe), int'(m_oe()));
            chk(rd_data === m_rd(int'(rd_addr)), "R2", int'(rd_data), int'(m_rd(int'(rd_addr))));
        end
    end

    // ---------------- stimulus helpers (each starts at a falling edge) ----------------
    task automatic wr(input int a, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = 4'(a);
        #5 v = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lit_count(input int bitn, input int n, output int cnt);
        cnt = 0;
        repeat (n) begin
            @(negedge clk);
            #5 if (led_oe[bitn]) cnt++;
        end
    endtask

    task automatic check_defaults(input string req);
        logic [7:0] v;
        chk(led_oe == 16'h0, req, int'(led_oe), 0);
        for (int a = 2; a <= 9; a++) begin
            rd(a, v);
            chk(v == ((a == 3 || a == 5) ? 8'h80 : 8'h00), req, int'(v),
                (a == 3 || a == 5) ? 128 : 0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] v;
        int cnt, t0, t1, t;
        logic prev;
        logic [15:0] snap;

        #1 rst_n = 1'b0;
        // R12: strobe presented while reset is held
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd6; wr_data = 8'h55;
        @(negedge clk);
        wr_en = 1'b0;
        #5 chk(led_oe == 16'h0, "R1", int'(led_oe), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #5 chk(led_oe == 16'h0, "R1", int'(led_oe), 0);
        rd(6, v);
        chk(v == 8'h00, "R12", int'(v), 0);
        check_defaults("R1");
        cmp_on = 1;

        // R2 / R3: all selectors lit, then readback
        for (int s = 6; s <= 9; s++) wr(s, 8'h55);
        for (int s = 6; s <= 9; s++) begin
            rd(s, v);
            chk(v == 8'h55, "R2", int'(v), 8'h55);
        end
        chk(led_oe == 16'hFFFF, "R3", int'(led_oe), 16'hFFFF);
        chk(led_lvl == 16'h0, "R3", int'(led_lvl), 0);

        // R3: mixed field codes in one byte (LED0=01, LED1=11, LED2=01, LED3=00)
        wr(6, 8'h1D);
        @(negedge clk);
        #5 chk(led_oe[0] == 1'b1, "R3", int'(led_oe[0]), 1);
        chk(led_oe[2] == 1'b1, "R3", int'(led_oe[2]), 1);
        chk(led_oe[3] == 1'b0, "R3", int'(led_oe[3]), 0);

        // R4: two-edge status latency
        @(negedge clk);
        pins = 16'h3CA5; rd_addr = 4'd0;
        #5 chk(rd_data == 8'h00, "R4", int'(rd_data), 0);
        @(negedge clk);
        #5 chk(rd_data == 8'h00, "R4", int'(rd_data), 0);
        @(negedge clk);
        #5 chk(rd_data == 8'hA5, "R4", int'(rd_data), 8'hA5);
        rd(1, v);
        chk(v == 8'h3C, "R4", int'(v), 8'h3C);

        // R10: read-only and unmapped addresses
        wr(0, 8'hFF);
        wr(12, 8'h77);
        rd(0, v);
        chk(v == 8'hA5, "R10", int'(v), 8'hA5);
        rd(12, v);
        chk(v == 8'h00, "R10", int'(v), 0);
        for (int s = 6; s <= 9; s++) begin
            rd(s, v);
            chk(v == ((s == 6) ? 8'h1D : 8'h55), "R10", int'(v), (s == 6) ? 8'h1D : 8'h55);
        end

        // R5: LED4-7 on channel 0, LED8-11 on channel 1
        wr(7, 8'hAA);
        wr(8, 8'hFF);
        wr(2, 0);
        wr(3, 8'h40);
        idle(600);
        lit_count(4, 256, cnt);
        chk(cnt == 64, "R5", cnt, 64);
        lit_count(8, 256, cnt);
        chk(cnt == 128, "R5", cnt, 128);

        // R8: timebase held low freezes the pads
        @(negedge clk);
        tick_en = 1'b0;
        #5 snap = led_oe;
        cnt = 0;
        repeat (300) begin
            @(negedge clk);
            #5 if (led_oe != snap) cnt++;
        end
        chk(cnt == 0, "R8", cnt, 0);
        @(negedge clk);
        tick_en = 1'b1;

        // R6: zero duty
        wr(3, 0);
        idle(300);
        lit_count(4, 256, cnt);
        chk(cnt == 0, "R6", cnt, 0);

        // R7: prescaler 3 on channel 1
        wr(4, 3);
        wr(5, 8'h40);
        idle(400);
        lit_count(8, 1024, cnt);
        chk(cnt == 256, "R7", cnt, 256);
        prev = 1'b1; t = 0; t0 = -1; t1 = -1;
        while (t1 < 0 && t < 3000) begin
            @(negedge clk);
            #5 t++;
            if (!prev && led_oe[8]) begin
                if (t0 < 0) t0 = t; else t1 = t;
            end
            prev = led_oe[8];
        end
        chk(t1 - t0 == 1024, "R7", t1 - t0, 1024);

        // R9: change held until the wrap
        wr(3, 8'h40);
        idle(300);
        do @(negedge clk); while (m_ph[0] != 5);
        wr_en = 1'b1; wr_addr = 4'd3; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        #5 chk(led_oe[4] == 1'b1, "R9", int'(led_oe[4]), 1);
        rd(3, v);
        chk(v == 8'h00, "R9", int'(v), 0);
        lit_count(4, 40, cnt);
        chk(cnt == 40, "R9", cnt, 40);
        idle(300);
        lit_count(4, 256, cnt);
        chk(cnt == 0, "R9", cnt, 0);

        // R11: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #5 chk(led_oe == 16'h0, "R11", int'(led_oe), 0);
        check_defaults("R11");

        idle(5);
        finish_run();
    end
endmodule